// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that lets an external host read and write a bank of 32 byte-wide control registers. The host frames each transfer with an active-low chip select and clocks it with SCLK, which idles low. The first byte it sends is a command byte. It holds a direction flag, a 5-bit register address and two spare bits. One data byte follows. For a write the data byte is shifted in from the host. For a read it is shifted out on SDO. Data moves least-significant bit first.

The serial inputs are oversampled in the local clock domain through a synchronizer chain. The port then detects SCLK edges itself. The register bank contents are presented in parallel on `regs_o` so that the rest of the chip can use them. The serial output is given as a data bit plus an output enable, and the pad drives SDO only while that enable is high.

Top module: `serreg_port`

## Requirements
- R1: After reset every register reads as 0x00 and `sdo_oe_o` is low.
- R2: Command bits are taken on rising SCLK edges in this order: first the direction flag, then address bits A0 to A4, then two spare bits that have no effect on the transfer.
- R3: A direction flag of 0 selects a write: the eight data bits that follow are taken D0 first on rising SCLK edges and stored into the addressed register.
- R4: A direction flag of 1 selects a read: the addressed register is driven on `sdo_o` D0 first. Each bit changes after a falling SCLK edge, and the first bit appears after the falling edge that follows the last command bit.
- R5: A read leaves every register unchanged.
- R6: `sdo_oe_o` is high only during a read, from the first data-phase falling SCLK edge until chip select is released. It stays low during the command byte and throughout a write.
- R7: If chip select is released before all eight write data bits have arrived, the register is unchanged, and the next transfer starts again with a command byte.
- R8: SCLK edges after the data byte and before chip select is released are ignored. They perform no further write or read.
- R9: Every address from 0x00 to 0x1F selects its own register, and each register is independent of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select from host, active low |
| sclk_i | input | 1 | Serial clock from host, idle low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for the SDO pad |
| regs_o | output | 256 | Register bank contents, register n at bits [8n+7:8n] |

## Verification
A serial input edge needs two synchronizer clocks plus one edge-detect clock before the port acts on it. SDO therefore moves three local clocks after a falling SCLK edge, and a completed write shows on `regs_o` four clocks after the final rising edge. The bench's reference model updates its expected registers, SDO value and enable at the moment it drives each host edge. It compares them with the ports on every clock, but only once five clocks have passed since the last input change. Host half-periods are eight clocks, so each comparison falls inside the settled window. Read bytes are also captured at the port just before each rising SCLK edge, as a host would sample them, and compared with the model.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] cmd_q, sr_q, wdata_q;
  logic [DATA_W-1:0] cmd_next, sr_in_next;
  logic [AW-1:0]     addr_q;
  logic              rw_q, sclk_d_q, sdo_q, oe_q, wr_en_q;
  logic              sclk_rise, sclk_fall, active;

  assign active     = !cs_n_s_i;
  assign sclk_rise  = active && sclk_s_i && !sclk_d_q;
  assign sclk_fall  = active && !sclk_s_i && sclk_d_q;
  assign cmd_next   = {sdi_s_i, cmd_q[DATA_W-1:1]};
  assign sr_in_next = {sdi_s_i, sr_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      sr_q    <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (!active) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_CMD: if (sclk_rise) begin
            cmd_q <= cmd_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              // flag is first in, so it sits at bit 0 once the byte is complete
              phase_q <= PH_DATA;
              cnt_q   <= '0;
              rw_q    <= cmd_next[0];
              addr_q  <= cmd_next[AW:1];
            end
          end
          PH_DATA: begin
            if (rw_q && sclk_fall) begin
              if (cnt_q == '0) begin
                sdo_q <= rd_data_i[0];
                sr_q  <= rd_data_i >> 1;
              end else begin
                sdo_q <= sr_q[0];
                sr_q  <= sr_q >> 1;
              end
              oe_q  <= 1'b1;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST) phase_q <= PH_DONE;
            end else if (!rw_q && sclk_rise) begin
              sr_q  <= sr_in_next;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST) begin
                wdata_q <= sr_in_next;
                wr_en_q <= 1'b1;
                phase_q <= PH_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign addr_o    = addr_q;
  assign wr_data_o = wdata_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  a_r6_oe_off_without_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !sdo_oe_o);
  a_r6_oe_rises_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(sclk_fall));
  a_r4_sdo_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdo_q));
  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  a_r5_no_write_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> !rw_q);
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] reg_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               reg_q[i] <= '0;
      else if (we_i && addr_i == AW'(i))         reg_q[i] <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = reg_q[i];

    a_r7_hold_unless_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == AW'(i)) |=> $stable(reg_q[i]));
  end

  assign rdata_o = reg_q[addr_i];
endmodule

// File: rtl/serreg_port.sv
module serreg_port #(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int unsigned AW = $clog2(NUM_REGS);

  logic              cs_n_s, sclk_s, sdi_s, wr_en;
  logic [AW-1:0]     addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  serreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    ({cs_n_s, sclk_s, sdi_s})
  );

  serreg_frame #(.DATA_W(DATA_W), .AW(AW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (cs_n_s),
    .sclk_s_i  (sclk_s),
    .sdi_s_i   (sdi_s),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .addr_o    (addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  serreg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .addr_i  (addr),
    .wdata_i (wr_data),
    .rdata_o (rd_data),
    .regs_o  (regs_o)
  );
endmodule

// File: tb/serreg_port_tb_top.sv
`timescale 1ns/1ps
module serreg_port_tb_top;
  localparam int HP = 8;
  localparam int SETTLE = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_ni = 1'b1;
  logic         sclk_i = 1'b0;
  logic         sdi_i = 1'b0;
  logic         sdo_o, sdo_oe_o;
  logic [255:0] regs_o;

  int           n_tests = 0, n_fail = 0, settle = 0;
  logic [7:0]   exp_regs [32];
  logic         exp_oe = 1'b0, exp_sdo = 1'b0;
  string        cur_tag = "R1";
  bit           done = 1'b0;

  always #4 clk_i = ~clk_i;

  serreg_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic mark();
    settle = 0;
  endtask

  // per-clock comparison against the reference model once inputs have settled
  always @(negedge clk_i) begin
    settle++;
    if (rst_ni && settle >= SETTLE && !done) begin
      for (int i = 0; i < 32; i++)
        chk(regs_o[i*8 +: 8] == exp_regs[i], cur_tag, $sformatf("reg[%0d]", i),
            regs_o[i*8 +: 8], exp_regs[i]);
      chk(sdo_oe_o == exp_oe, (exp_oe ? "R6" : "R6"), "sdo_oe", sdo_oe_o, exp_oe);
      if (exp_oe) chk(sdo_o == exp_sdo, "R4", "sdo", sdo_o, exp_sdo);
    end
  end

  task automatic xfer(input bit rw, input int addr, input logic [7:0] wd, input int nd,
                      input logic [1:0] rsv, input int extra, input string tag,
                      output logic [7:0] rd);
    logic [7:0] cmd;
    logic [4:0] a;
    a = addr[4:0];
    cmd = {rsv, a, rw};
    rd = '0;
    cur_tag = tag;
    cs_ni = 1'b0; mark(); tick(HP);
    for (int i = 0; i < 8; i++) begin
      sdi_i = cmd[i]; mark(); tick(HP);
      sclk_i = 1'b1; mark(); tick(HP);
      sclk_i = 1'b0;
      if (i == 7 && rw) begin exp_oe = 1'b1; exp_sdo = exp_regs[a][0]; end
      mark();
    end
    for (int j = 0; j < nd; j++) begin
      if (!rw) sdi_i = wd[j];
      mark(); tick(HP);
      if (rw) rd[j] = sdo_o;
      sclk_i = 1'b1;
      if (!rw && j == 7) exp_regs[a] = wd;
      mark(); tick(HP);
      sclk_i = 1'b0;
      if (rw && j < 7) exp_sdo = exp_regs[a][j+1];
      mark();
    end
    for (int k = 0; k < extra; k++) begin
      sdi_i = ~sdi_i; mark(); tick(HP);
      sclk_i = 1'b1; mark(); tick(HP);
      sclk_i = 1'b0; mark();
    end
    tick(HP);
    cs_ni = 1'b1; exp_oe = 1'b0; mark();
    tick(2*HP);
  endtask

  task automatic rd_chk(input int addr, input string tag);
    logic [7:0] got;
    logic [7:0] exp;
    exp = exp_regs[addr];
    xfer(1'b1, addr, 8'h00, 8, 2'b00, 0, tag, got);
    chk(got == exp, tag, $sformatf("read byte @%0h", addr), got, exp);
  endtask

  task automatic wr(input int addr, input logic [7:0] d, input logic [1:0] rsv,
                    input string tag);
    logic [7:0] unused;
    xfer(1'b0, addr, d, 8, rsv, 0, tag, unused);
  endtask

  initial begin
    logic [7:0] dummy;
    for (int i = 0; i < 32; i++) exp_regs[i] = 8'h00;
    tick(5);
    rst_ni = 1'b1; mark();
    tick(8);
    // R1: reset state
    chk(regs_o == '0, "R1", "regs after reset", regs_o[31:0], 0);
    chk(sdo_oe_o == 1'b0, "R1", "sdo_oe after reset", sdo_oe_o, 0);

    wr(0, 8'hA5, 2'b00, "R3");
    wr(31, 8'h3C, 2'b00, "R9");
    wr(11, 8'h81, 2'b11, "R2");        // spare bits set, no effect
    wr(1, 8'h6E, 2'b10, "R9");         // neighbour/alias check vs 0x11
    chk(regs_o[17*8 +: 8] == 8'h00, "R9", "reg 0x11 untouched", regs_o[17*8 +: 8], 0);
    chk(regs_o[11*8 +: 8] == 8'h81, "R3", "lsb-first write", regs_o[11*8 +: 8], 8'h81);

    rd_chk(0, "R4");
    rd_chk(31, "R4");
    rd_chk(11, "R5");
    rd_chk(5, "R1");
    rd_chk(1, "R2");

    // R7: abort mid-write, then a fresh transfer works
    xfer(1'b0, 11, 8'h00, 5, 2'b00, 0, "R7", dummy);
    chk(regs_o[11*8 +: 8] == 8'h81, "R7", "aborted write", regs_o[11*8 +: 8], 8'h81);
    rd_chk(11, "R7");
    xfer(1'b1, 31, 8'h00, 3, 2'b00, 0, "R7", dummy);
    wr(20, 8'h01, 2'b00, "R7");

    // R8: trailing edges after the byte
    xfer(1'b0, 18, 8'h5A, 8, 2'b00, 9, "R8", dummy);
    chk(regs_o[18*8 +: 8] == 8'h5A, "R8", "no extra write", regs_o[18*8 +: 8], 8'h5A);
    chk(regs_o[19*8 +: 8] == 8'h00, "R8", "neighbour clean", regs_o[19*8 +: 8], 0);
    rd_chk(18, "R8");
    xfer(1'b1, 0, 8'h00, 8, 2'b00, 4, "R8", dummy);
    chk(dummy == 8'hA5, "R8", "read before trailing edges", dummy, 8'hA5);

    wr(31, 8'hFF, 2'b01, "R9");
    rd_chk(31, "R9");
    rd_chk(20, "R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule